// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block sits between a processor load/store port and a block-wide memory port. A request address is split into a tag, a set index and a byte offset within the block. Both lines of the indexed set are compared in parallel. A hit completes in the same cycle: a read returns the addressed word, and a write merges the enabled bytes into the line.

On a miss the request is held with `ready_o` low. The cache chooses a victim line. If that line is valid and dirty, its whole block is first written back to memory. The missing block is then fetched into the victim line, and the request completes in a final respond cycle.

Writes follow the write-back, write-allocate policy. Memory changes only when a dirty line is evicted. Between transactions, the memory port moves whole blocks, addressed by block number.

Top module: `cache_2way`

## Requirements
- R1: The address splits, from high to low, into tag, set index (log2 NUM_SETS bits) and offset (log2 BLOCK_BYTES bits). Bits [OFF_W-1:2] of the offset select the 32-bit word. With the defaults (16-byte blocks, 8 sets, 14-bit address), address 0x1833 falls in set 3, word 0, and fetches block 0x183.
- R2: After reset no line is valid, so the first access to any block reports `miss_o`.
- R3: A request whose tag matches a valid line of its set raises `hit_o` and `ready_o` in the same cycle, with no memory transaction. `hit_o` and `miss_o` are never high together.
- R4: Read data equals the most recent value written to that address by the processor, or the initial memory contents if it was never written.
- R5: A write hit updates only the cached line. No memory write occurs until that line is evicted.
- R6: A write miss first fetches the block with a memory read and then merges the write. The other words of the block keep their memory values.
- R7: A miss fills an invalid way of the set if there is one. When both ways are valid, it replaces the way not used most recently; both hits and fills count as use.
- R8: Evicting a dirty line writes its full block, including all processor writes, to the victim's block address before the refill. Evicting a clean line performs no memory write.
- R9: Two blocks mapping to the same set both stay resident: after both are loaded, alternating accesses to them all hit.
- R10: Byte enables `be_i` (bit k covers bits 8k+7:8k of the word) select which bytes a write changes. Disabled bytes keep their value.
- R11: A miss holds `ready_o` low until the respond cycle. With a one-cycle memory, a clean miss completes in the 4th cycle of the request and a dirty miss in the 6th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Processor request valid |
| we_i | input | 1 | Request is a write |
| addr_i | input | ADDR_W | Byte address |
| be_i | input | 4 | Byte enables for writes |
| wdata_i | input | 32 | Write data word |
| rdata_o | output | 32 | Read data word, valid with ready_o |
| ready_o | output | 1 | Request completes this cycle |
| hit_o | output | 1 | Request hits in the lookup cycle |
| miss_o | output | 1 | Request misses in the lookup cycle |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | Memory transaction is a block write |
| mem_addr_o | output | ADDR_W-OFF_W | Block number |
| mem_wdata_o | output | 8*BLOCK_BYTES | Block written back |
| mem_rdata_i | input | 8*BLOCK_BYTES | Block returned for a refill |
| mem_ack_i | input | 1 | One-cycle completion of the memory transaction |

## Verification
The assertions rely on two input rules. The processor keeps `req_i`, `we_i` and `addr_i` unchanged while `ready_o` is low. Memory answers each transaction with a single `mem_ack_i` pulse while `mem_req_o` is high. The bench holds every request from one falling edge until the cycle in which it sees `ready_o`, and then drops it. Its memory model raises a one-cycle acknowledge one cycle after it sees a request and then waits for the next request. The input-hold rule is also written as a property, so any departure from it in the stimulus is flagged.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_RESP  = 2'd3
  } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int NUM_SETS = 8,
  parameter int IDX_W    = 3,
  parameter int TAG_W    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             access_i,
  input  logic             access_wr_i,
  input  logic             fill_i,
  input  logic             fill_way_i,
  input  logic             rd_way_i,
  output logic             hit_o,
  output logic             hit_way_o,
  output logic             victim_way_o,
  output logic             rd_dirty_o,
  output logic [TAG_W-1:0] rd_tag_o
);
  logic [1:0]       valid_q [NUM_SETS];
  logic [1:0]       dirty_q [NUM_SETS];
  logic [TAG_W-1:0] tag_q   [NUM_SETS][2];
  logic             nmru_q  [NUM_SETS];
  logic [1:0]       way_hit;

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign way_hit[w] = valid_q[idx_i][w] && (tag_q[idx_i][w] == tag_i);
  end

  assign hit_o     = |way_hit;
  assign hit_way_o = way_hit[1];
  // invalid way first, otherwise the way not touched last
  assign victim_way_o = !valid_q[idx_i][0] ? 1'b0 :
                        !valid_q[idx_i][1] ? 1'b1 : nmru_q[idx_i];
  assign rd_dirty_o = valid_q[idx_i][rd_way_i] && dirty_q[idx_i][rd_way_i];
  assign rd_tag_o   = tag_q[idx_i][rd_way_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s]  <= '0;
        dirty_q[s]  <= '0;
        nmru_q[s]   <= 1'b0;
        tag_q[s][0] <= '0;
        tag_q[s][1] <= '0;
      end
    end else if (fill_i) begin
      valid_q[idx_i][fill_way_i] <= 1'b1;
      dirty_q[idx_i][fill_way_i] <= 1'b0;
      tag_q[idx_i][fill_way_i]   <= tag_i;
      nmru_q[idx_i]              <= ~fill_way_i;
    end else if (access_i) begin
      if (access_wr_i) dirty_q[idx_i][hit_way_o] <= 1'b1;
      nmru_q[idx_i] <= ~hit_way_o;
    end
  end
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int NUM_SETS = 8,
  parameter int IDX_W    = 3,
  parameter int LINE_W   = 128,
  parameter int WORD_W   = 32,
  parameter int WSEL_W   = 2
) (
  input  logic                clk_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic                way_i,
  input  logic [WSEL_W-1:0]   wsel_i,
  input  logic                wr_word_i,
  input  logic [WORD_W/8-1:0] be_i,
  input  logic [WORD_W-1:0]   wdata_i,
  input  logic                fill_i,
  input  logic [LINE_W-1:0]   fill_line_i,
  output logic [WORD_W-1:0]   rdata_o,
  output logic [LINE_W-1:0]   line_o
);
  localparam int WBYTES = WORD_W / 8;

  logic [LINE_W-1:0] line_q [NUM_SETS][2];

  assign line_o  = line_q[idx_i][way_i];
  assign rdata_o = line_o[wsel_i*WORD_W +: WORD_W];

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      line_q[idx_i][way_i] <= fill_line_i;
    end else if (wr_word_i) begin
      for (int b = 0; b < WBYTES; b++)
        if (be_i[b])
          line_q[idx_i][way_i][(wsel_i*WBYTES + b)*8 +: 8] <= wdata_i[b*8 +: 8];
    end
  end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic         hit_i,
  input  logic         victim_way_i,
  input  logic         victim_dirty_i,
  input  logic         mem_ack_i,
  output cache_state_e state_o,
  output logic         victim_q_o
);
  cache_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i && !hit_i) state_d = victim_dirty_i ? ST_WBACK : ST_FILL;
      ST_WBACK: if (mem_ack_i) state_d = ST_FILL;
      ST_FILL:  if (mem_ack_i) state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      victim_q_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_i && !hit_i) victim_q_o <= victim_way_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/cache_2way.sv
module cache_2way
  import cache_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int BLOCK_BYTES = 16,
  parameter int NUM_SETS    = 8,
  localparam int OFF_W   = $clog2(BLOCK_BYTES),
  localparam int IDX_W   = $clog2(NUM_SETS),
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W  = BLOCK_BYTES * 8,
  localparam int BADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [3:0]         be_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               ready_o,
  output logic               hit_o,
  output logic               miss_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [BADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0]  mem_wdata_o,
  input  logic [LINE_W-1:0]  mem_rdata_i,
  input  logic               mem_ack_i
);
  localparam int WSEL_W = OFF_W - 2;

  logic [TAG_W-1:0]  tag, rd_tag;
  logic [IDX_W-1:0]  idx;
  logic [WSEL_W-1:0] wsel;
  logic              lk_hit, hit_way, victim_way, victim_q, rd_way, rd_dirty;
  logic              access, fill, data_way;
  cache_state_e      state;

  assign {tag, idx} = addr_i[ADDR_W-1:OFF_W];
  assign wsel       = addr_i[OFF_W-1:2];

  assign hit_o     = (state == ST_IDLE) && req_i && lk_hit;
  assign miss_o    = (state == ST_IDLE) && req_i && !lk_hit;
  assign ready_o   = hit_o || (state == ST_RESP);
  assign access    = ready_o;
  assign fill      = (state == ST_FILL) && mem_ack_i;
  assign rd_way    = (state == ST_IDLE) ? victim_way : victim_q;
  assign data_way  = (state == ST_WBACK || state == ST_FILL) ? victim_q : hit_way;

  assign mem_req_o  = (state == ST_WBACK) || (state == ST_FILL);
  assign mem_we_o   = (state == ST_WBACK);
  assign mem_addr_o = (state == ST_WBACK) ? {rd_tag, idx} : {tag, idx};

  cache_ctrl i_ctrl (
    .clk_i, .rst_ni, .req_i,
    .hit_i          (lk_hit),
    .victim_way_i   (victim_way),
    .victim_dirty_i (rd_dirty),
    .mem_ack_i,
    .state_o        (state),
    .victim_q_o     (victim_q)
  );

  cache_tag_store #(.NUM_SETS(NUM_SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
    .clk_i, .rst_ni,
    .idx_i        (idx),
    .tag_i        (tag),
    .access_i     (access),
    .access_wr_i  (we_i),
    .fill_i       (fill),
    .fill_way_i   (victim_q),
    .rd_way_i     (rd_way),
    .hit_o        (lk_hit),
    .hit_way_o    (hit_way),
    .victim_way_o (victim_way),
    .rd_dirty_o   (rd_dirty),
    .rd_tag_o     (rd_tag)
  );

  cache_data_store #(.NUM_SETS(NUM_SETS), .IDX_W(IDX_W), .LINE_W(LINE_W),
                     .WORD_W(32), .WSEL_W(WSEL_W)) i_data (
    .clk_i,
    .idx_i       (idx),
    .way_i       (data_way),
    .wsel_i      (wsel),
    .wr_word_i   (access && we_i),
    .be_i,
    .wdata_i,
    .fill_i      (fill),
    .fill_line_i (mem_rdata_i),
    .rdata_o,
    .line_o      (mem_wdata_o)
  );
endmodule

// File: rtl/cache_2way_chk.sv
module cache_2way_chk #(
  parameter int ADDR_W  = 14,
  parameter int BADDR_W = 10
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               ready_o,
  input logic               hit_o,
  input logic               miss_o,
  input logic               mem_req_o,
  input logic               mem_we_o,
  input logic [BADDR_W-1:0] mem_addr_o,
  input logic               mem_ack_i
);
  assert_hit_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));
  assert_hit_completes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ready_o);
  assert_miss_stalls_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> !ready_o);
  assert_miss_to_memory_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |=> mem_req_o);
  assert_hit_no_memory_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> !mem_req_o);
  assert_mem_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  assert_req_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !ready_o |=> req_i && $stable(addr_i) && $stable(we_i));
endmodule

bind cache_2way cache_2way_chk #(.ADDR_W(ADDR_W), .BADDR_W(BADDR_W)) i_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .ready_o, .hit_o, .miss_o,
  .mem_req_o, .mem_we_o, .mem_addr_o, .mem_ack_i
);

// File: tb/test_cache_2way.sv
module test_cache_2way;
  localparam int ADDR_W = 14;
  localparam int NBLK   = 1024;

  logic         clk_i = 1'b0, rst_ni = 1'b0;
  logic         req_i = 1'b0, we_i = 1'b0;
  logic [13:0]  addr_i = '0;
  logic [3:0]   be_i = '0;
  logic [31:0]  wdata_i = '0, rdata_o;
  logic         ready_o, hit_o, miss_o, mem_req_o, mem_we_o;
  logic [9:0]   mem_addr_o;
  logic [127:0] mem_wdata_o, mem_rdata_i = '0;
  logic         mem_ack_i = 1'b0;

  logic [127:0] backing [NBLK];
  logic [127:0] ref_blk [NBLK];
  int wr_cnt = 0, rd_cnt = 0;
  logic [9:0] last_rd = '0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  cache_2way i_cache_2way (.*);

  // one-cycle memory model
  always @(posedge clk_i) begin
    mem_ack_i <= mem_req_o && !mem_ack_i;
    if (mem_req_o && !mem_ack_i) begin
      mem_rdata_i <= backing[mem_addr_o];
      if (mem_we_o) begin
        backing[mem_addr_o] <= mem_wdata_o;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt  <= rd_cnt + 1;
        last_rd <= mem_addr_o;
      end
    end
  end

  task automatic check(bit ok, string rq, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [13:0] mk(int tag, int set, int word);
    return 14'((tag << 7) | (set << 4) | (word << 2));
  endfunction

  function automatic logic [31:0] ref_word(logic [13:0] a);
    return ref_blk[a[13:4]][a[3:2]*32 +: 32];
  endfunction

  task automatic access(input logic [13:0] a, input bit w, input logic [3:0] be,
                        input logic [31:0] d, output bit hit1, output logic [31:0] rd,
                        output int cyc);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; be_i = be; wdata_i = d;
    cyc = 0;
    #2;
    hit1 = hit_o;
    forever begin
      cyc++;
      if (ready_o) break;
      @(negedge clk_i); #2;
    end
    rd = rdata_o;
    if (w)
      for (int b = 0; b < 4; b++)
        if (be[b]) ref_blk[a[13:4]][a[3:2]*32 + b*8 +: 8] = d[b*8 +: 8];
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd_chk(logic [13:0] a, bit exp_hit, string rq);
    bit h; logic [31:0] d; int c;
    access(a, 1'b0, 4'h0, 32'h0, h, d, c);
    check(h == exp_hit, rq, 128'(h), 128'(exp_hit));
    check(d == ref_word(a), "R4", 128'(d), 128'(ref_word(a)));
  endtask

  task automatic t_reset;
    check(!ready_o && !mem_req_o && !hit_o && !miss_o, "R2",
          {ready_o, mem_req_o, hit_o, miss_o}, 0);
  endtask

  task automatic t_split;
    bit h; logic [31:0] d; int c;
    access(14'h1833, 1'b0, 4'h0, 0, h, d, c);
    check(!h, "R2", 128'(h), 0);
    check(last_rd == 10'h183, "R1", 128'(last_rd), 128'h183);
    check(d == ref_word(14'h1833), "R1", 128'(d), 128'(ref_word(14'h1833)));
    check(c == 4, "R11", 128'(c), 4);
    rd_chk(14'h183c, 1'b1, "R3");
  endtask

  task automatic t_write_hit;
    bit h; logic [31:0] d; int c; int w0;
    rd_chk(mk(1, 0, 0), 1'b0, "R2");
    w0 = wr_cnt;
    access(mk(1, 0, 2), 1'b1, 4'hf, 32'hdead_beef, h, d, c);
    check(h, "R3", 128'(h), 1);
    check(wr_cnt == w0, "R5", 128'(wr_cnt), 128'(w0));
    check(backing[mk(1,0,0) >> 4] != ref_blk[mk(1,0,0) >> 4], "R5",
          backing[mk(1,0,0) >> 4], ref_blk[mk(1,0,0) >> 4]);
    rd_chk(mk(1, 0, 2), 1'b1, "R5");
    access(mk(1, 0, 2), 1'b1, 4'b0101, 32'h1122_3344, h, d, c);
    rd_chk(mk(1, 0, 2), 1'b1, "R10");
    check(ref_word(mk(1,0,2)) == 32'hde22_be44, "R10", 128'(ref_word(mk(1,0,2))), 128'hde22be44);
  endtask

  task automatic t_write_miss;
    bit h; logic [31:0] d; int c; int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    access(mk(2, 1, 1), 1'b1, 4'hf, 32'hcafe_f00d, h, d, c);
    check(!h && rd_cnt == r0 + 1 && wr_cnt == w0, "R6", 128'(rd_cnt - r0), 1);
    rd_chk(mk(2, 1, 1), 1'b1, "R6");
    rd_chk(mk(2, 1, 0), 1'b1, "R6");
    rd_chk(mk(2, 1, 3), 1'b1, "R6");
  endtask

  task automatic t_nmru;
    rd_chk(mk(1, 5, 0), 1'b0, "R7");
    rd_chk(mk(2, 5, 0), 1'b0, "R7");
    rd_chk(mk(1, 5, 1), 1'b1, "R7");
    rd_chk(mk(3, 5, 0), 1'b0, "R7");
    rd_chk(mk(1, 5, 2), 1'b1, "R7");
    rd_chk(mk(2, 5, 0), 1'b0, "R7");
  endtask

  task automatic t_writeback;
    bit h; logic [31:0] d; int c; int w0;
    access(mk(1, 6, 3), 1'b1, 4'hf, 32'h0bad_cafe, h, d, c);
    access(mk(1, 6, 0), 1'b1, 4'h3, 32'h0000_5a5a, h, d, c);
    rd_chk(mk(2, 6, 0), 1'b0, "R7");
    rd_chk(mk(2, 6, 1), 1'b1, "R7");
    w0 = wr_cnt;
    access(mk(3, 6, 0), 1'b0, 4'h0, 0, h, d, c);
    check(wr_cnt == w0 + 1, "R8", 128'(wr_cnt - w0), 1);
    check(backing[mk(1,6,0) >> 4] == ref_blk[mk(1,6,0) >> 4], "R8",
          backing[mk(1,6,0) >> 4], ref_blk[mk(1,6,0) >> 4]);
    check(c == 6, "R11", 128'(c), 6);
    w0 = wr_cnt;
    access(mk(4, 6, 0), 1'b0, 4'h0, 0, h, d, c);
    check(wr_cnt == w0 && c == 4, "R8", 128'(wr_cnt - w0), 0);
    rd_chk(mk(1, 6, 0), 1'b0, "R8");
  endtask

  task automatic t_conflict;
    rd_chk(mk(5, 2, 0), 1'b0, "R9");
    rd_chk(mk(6, 2, 0), 1'b0, "R9");
    for (int i = 0; i < 3; i++) begin
      rd_chk(mk(5, 2, i), 1'b1, "R9");
      rd_chk(mk(6, 2, i), 1'b1, "R9");
    end
  endtask

  initial begin
    for (int i = 0; i < NBLK; i++) begin
      for (int j = 0; j < 4; j++)
        backing[i][j*32 +: 32] = 32'ha000_0000 ^ (i << 8) ^ (j * 32'h1111);
      ref_blk[i] = backing[i];
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #2;
    t_reset;
    t_split;
    t_write_hit;
    t_write_miss;
    t_nmru;
    t_writeback;
    t_conflict;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule